// File: doc/BRIEF.md
# DMA Slave Request Controller

This block is the DMA slave side of a peripheral packet FIFO. It serves the one endpoint that is currently chosen for DMA. It raises a request toward an external DMA controller, accepts that controller's acknowledge and end-of-transfer signals, and moves one byte or one 16-bit word between the bus and the FIFO on each data strobe. The direction comes from the endpoint's direction bit. An OUT endpoint is read by the bus and popped from the FIFO. An IN endpoint is written from the bus and pushed into the FIFO.

Two strobe schemes are supported. In the first, separate read and write strobes move data while acknowledge is active. In the second, acknowledge alone is the data strobe and the read and write inputs are ignored. Request, acknowledge and end-of-transfer each have a configurable active level. Requests come in single-transfer or burst form. A 16-bit byte counter is loaded when DMA is enabled.

A transfer stops for one of four reasons: an external end-of-transfer, the counter running out, a short or empty OUT packet, or software clearing the enable. The cause is kept in a sticky status. When auto-reload is set, the block reloads the counter and carries on without software help.

Top module: `dma_slave_req`

## Requirements
- R1: Each of `cfgReqPol`, `cfgAckPol` and `cfgEotPol` gives the active level of its pin: 1 means active high and 0 means active low. When no request is pending, `dmaReq` sits at the inactive level.
- R2: A request is active only while DMA is enabled and running and the source is ready. For OUT (`epIsIn`=0) the source is ready when a packet is present and it is not an empty packet. For IN (`epIsIn`=1) it is ready when FIFO space is free.
- R3: With `cfgAckOnly`=0, one transfer happens on each rising edge of (acknowledge active AND `busRd` for OUT, or `busWr` for IN). With `cfgAckOnly`=1, one transfer happens on each rising edge of acknowledge active, and `busRd`/`busWr` have no effect. Acknowledge alone, or a strobe without acknowledge, moves nothing in the first scheme.
- R4: With `cfgBurst`=0 the request drops after every transfer. With `cfgBurst`=1 it drops after `cfgBurstLen`+1 transfers (1 to 16). In both cases it returns once acknowledge goes inactive.
- R5: The counter is loaded from `cfgCount` on a rising edge of `cfgEnable`. Each transfer lowers it by 1, or by 2 when `cfgWide`=1, and it stops at zero. With `cfgCntEn`=1, the transfer that brings it to zero terminates DMA. A count of N therefore takes ceil(N/step) transfers.
- R6: A change of end-of-transfer to active while running terminates DMA. It also pulses `fifoFlush` for OUT or `fifoCommit` for IN, in the cycle after the edge.
- R7: With `cfgShortEn`=1 on OUT, a transfer made while `fifoShort` and `fifoLast` are both high terminates DMA. With `cfgShortEn`=0 it does not.
- R8: With `cfgShortEn`=1 on OUT, `fifoEmptyPkt` high while running terminates DMA without any transfer and pulses `fifoFlush`.
- R9: A falling edge of `cfgEnable` while running terminates DMA at once.
- R10: With `cfgAutoReload`=1, every termination except disable reloads the counter from `cfgCount` and keeps DMA running. The request then comes back under R2: at once for IN, or when an OUT packet is present.
- R11: For OUT, `busDataOut` carries `fifoRdData` while `busDataOe` is high during an active strobe, and `fifoRd` pulses in the cycle after the transfer. For IN, `fifoWr` pulses in the cycle after the transfer, with `fifoWrData` holding the bus word. With `cfgWide`=0 the upper byte of both is zero.
- R12: `xferDone` and the one-hot `termCause` are sticky and are cleared by the next rising edge of `cfgEnable`. The bits are: bit0 external, bit1 count, bit2 short/empty packet, bit3 disable. If causes coincide, disable wins over external, external over short, and short over count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | DMA enable; a rising edge starts a run |
| cfgAckOnly | input | 1 | 1: acknowledge is the data strobe |
| cfgBurst | input | 1 | 1: burst requests, 0: single transfers |
| cfgBurstLen | input | 4 | Transfers per burst minus one |
| cfgWide | input | 1 | 1: 16-bit transfers |
| cfgCntEn | input | 1 | Enable counter termination |
| cfgShortEn | input | 1 | Enable short/empty packet termination |
| cfgAutoReload | input | 1 | Reload and restart after termination |
| cfgReqPol | input | 1 | Request active level |
| cfgAckPol | input | 1 | Acknowledge active level |
| cfgEotPol | input | 1 | End-of-transfer active level |
| cfgCount | input | 16 | Byte count to load |
| epIsIn | input | 1 | Selected endpoint direction, 1 = IN |
| fifoPktReady | input | 1 | OUT packet present |
| fifoSpace | input | 1 | IN buffer space free |
| fifoShort | input | 1 | Current OUT packet is short |
| fifoLast | input | 1 | Next read empties the OUT packet |
| fifoEmptyPkt | input | 1 | Current OUT packet is empty |
| fifoRdData | input | 16 | FIFO head data for OUT |
| busAck | input | 1 | DMA acknowledge pin |
| busEot | input | 1 | End-of-transfer pin |
| busRd | input | 1 | Read strobe, active high |
| busWr | input | 1 | Write strobe, active high |
| busDataIn | input | 16 | Bus data for IN |
| dmaReq | output | 1 | DMA request pin |
| busDataOut | output | 16 | Bus data for OUT |
| busDataOe | output | 1 | Drive enable for busDataOut |
| fifoRd | output | 1 | Pop one byte/word |
| fifoWr | output | 1 | Push fifoWrData |
| fifoWrData | output | 16 | Data to push |
| fifoFlush | output | 1 | Discard current OUT buffer |
| fifoCommit | output | 1 | Commit partial IN packet |
| xferDone | output | 1 | Sticky termination flag |
| termCause | output | 4 | Sticky one-hot termination cause |

## Verification
The hardest situation to reach from the ports is auto-reload after an early termination. A reload that is missing looks the same as a counter that still holds the rest of its old count. The bench loads a count of two and makes one transfer, then forces an external end-of-transfer. It then shows that one more transfer leaves the cause as external and that a second one changes it to count, which can only happen if the counter was refilled. The count sweep covers every count from 1 to 6 for both widths and both strobe schemes, which exposes off-by-one errors at the zero boundary.

// File: rtl/dma_slave_pkg.sv
package dma_slave_pkg;
  localparam int CAUSE_W   = 4;
  localparam int CAUSE_EXT = 0;
  localparam int CAUSE_CNT = 1;
  localparam int CAUSE_SHP = 2;
  localparam int CAUSE_DIS = 3;

  typedef struct packed {
    logic load;   // reload counter from configuration
    logic dec;    // one transfer happened
    logic pop;    // OUT transfer: pop from FIFO
    logic push;   // IN transfer: push to FIFO
    logic drive;  // drive the bus with FIFO head
  } dpStrobes_t;
endpackage

// File: rtl/dma_slave_datapath.sv
module dma_slave_datapath
  import dma_slave_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic              cfgWide,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              cntWillZero,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              fifoRd,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoWrData
);
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  step;
  logic [DATA_W-1:0] laneMask;

  assign step        = cfgWide ? CNT_W'(LANES) : CNT_W'(1);
  assign cntWillZero = (cnt <= step);

  // lane 0 always passes; upper lanes only in wide mode
  for (genvar g = 0; g < LANES; g++) begin : gLane
    if (g == 0) begin : gLow
      assign laneMask[BYTE_W-1:0] = '1;
    end else begin : gHigh
      assign laneMask[g*BYTE_W +: BYTE_W] = {BYTE_W{cfgWide}};
    end
  end

  assign busDataOut = fifoRdData & laneMask;
  assign busDataOe  = strb.drive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      fifoRd     <= 1'b0;
      fifoWr     <= 1'b0;
      fifoWrData <= '0;
    end else begin
      if (strb.load)      cnt <= cfgCount;
      else if (strb.dec)  cnt <= cntWillZero ? '0 : cnt - step;
      fifoRd <= strb.pop;
      fifoWr <= strb.push;
      if (strb.push) fifoWrData <= busDataIn & laneMask;
    end
  end

  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> cnt == $past(cfgCount)); // R5
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !strb.load) |=> (cnt < $past(cnt)) || ($past(cnt) == '0)); // R5
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !cfgWide) |=> fifoWrData[DATA_W-1:BYTE_W] == '0); // R11
endmodule

// File: rtl/dma_slave_ctrl.sv
module dma_slave_ctrl
  import dma_slave_pkg::*;
#(
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgAckOnly,
  input  logic               cfgBurst,
  input  logic [BURST_W-1:0] cfgBurstLen,
  input  logic               cfgCntEn,
  input  logic               cfgShortEn,
  input  logic               cfgAutoReload,
  input  logic               cfgReqPol,
  input  logic               cfgAckPol,
  input  logic               cfgEotPol,
  input  logic               epIsIn,
  input  logic               fifoPktReady,
  input  logic               fifoSpace,
  input  logic               fifoShort,
  input  logic               fifoLast,
  input  logic               fifoEmptyPkt,
  input  logic               busAck,
  input  logic               busEot,
  input  logic               busRd,
  input  logic               busWr,
  input  logic               cntWillZero,
  output dpStrobes_t         strb,
  output logic               dmaReq,
  output logic               fifoFlush,
  output logic               fifoCommit,
  output logic               xferDone,
  output logic [CAUSE_W-1:0] termCause
);
  logic run, enPrev, strobePrev, eotPrev, gap;
  logic [BURST_W-1:0] beat;

  logic ackAct, eotAct, strobeNow, xfer, enRise, enFall;
  logic extTerm, cntTerm, shortTerm, emptyTerm, disTerm, anyTerm, reload;
  logic endBurst, srcReady, reqInt;
  logic [CAUSE_W-1:0] causeSel;

  assign ackAct    = (busAck == cfgAckPol);
  assign eotAct    = (busEot == cfgEotPol);
  assign strobeNow = cfgAckOnly ? ackAct : (ackAct && (epIsIn ? busWr : busRd));
  assign enRise    = cfgEnable && !enPrev;
  assign enFall    = !cfgEnable && enPrev;
  assign xfer      = run && cfgEnable && strobeNow && !strobePrev;

  assign extTerm   = run && cfgEnable && eotAct && !eotPrev;
  assign cntTerm   = xfer && cfgCntEn && cntWillZero;
  assign shortTerm = xfer && !epIsIn && cfgShortEn && fifoShort && fifoLast;
  assign emptyTerm = run && cfgEnable && !epIsIn && cfgShortEn && fifoEmptyPkt;
  assign disTerm   = run && enFall;
  assign anyTerm   = disTerm || extTerm || shortTerm || emptyTerm || cntTerm;
  assign reload    = anyTerm && !disTerm && cfgAutoReload;

  // one-hot cause with fixed priority: disable, external, short, count
  always_comb begin
    causeSel = '0;
    if (disTerm)                     causeSel[CAUSE_DIS] = 1'b1;
    else if (extTerm)                causeSel[CAUSE_EXT] = 1'b1;
    else if (shortTerm || emptyTerm) causeSel[CAUSE_SHP] = 1'b1;
    else if (cntTerm)                causeSel[CAUSE_CNT] = 1'b1;
  end

  assign endBurst = xfer && (!cfgBurst || beat == cfgBurstLen);
  assign srcReady = epIsIn ? fifoSpace : (fifoPktReady && !fifoEmptyPkt);
  assign reqInt   = run && cfgEnable && srcReady && !gap;
  assign dmaReq   = cfgReqPol ? reqInt : !reqInt;

  always_comb begin
    strb.load  = enRise || reload;
    strb.dec   = xfer;
    strb.pop   = xfer && !epIsIn;
    strb.push  = xfer && epIsIn;
    strb.drive = run && cfgEnable && !epIsIn && strobeNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run        <= 1'b0;
      enPrev     <= 1'b0;
      strobePrev <= 1'b0;
      eotPrev    <= 1'b0;
      gap        <= 1'b0;
      beat       <= '0;
      xferDone   <= 1'b0;
      termCause  <= '0;
      fifoFlush  <= 1'b0;
      fifoCommit <= 1'b0;
    end else begin
      enPrev     <= cfgEnable;
      strobePrev <= strobeNow;
      eotPrev    <= eotAct;

      if (enRise)                    run <= 1'b1;
      else if (anyTerm && !reload)   run <= 1'b0;
      else if (!cfgEnable)           run <= 1'b0;

      if (enRise)        gap <= 1'b0;
      else if (endBurst) gap <= 1'b1;
      else if (!ackAct)  gap <= 1'b0;

      if (enRise || anyTerm || endBurst) beat <= '0;
      else if (xfer)                     beat <= beat + 1'b1;

      if (enRise) begin
        xferDone  <= 1'b0;
        termCause <= '0;
      end else if (anyTerm) begin
        xferDone  <= 1'b1;
        termCause <= causeSel;
      end

      fifoFlush  <= anyTerm && ((causeSel[CAUSE_EXT] && !epIsIn) ||
                                (causeSel[CAUSE_SHP] && emptyTerm));
      fifoCommit <= anyTerm && causeSel[CAUSE_EXT] && epIsIn;
    end
  end

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(termCause)); // R12
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    reqInt |-> (cfgEnable && run)); // R2
  AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !cfgBurst) |=> !reqInt); // R4
  AST_STOP_AFTER_TERM: assert property (@(posedge clk) disable iff (!rstN)
    (anyTerm && cfgEnable && !cfgAutoReload) |=> !reqInt); // R6
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (anyTerm && !enRise) |=> xferDone); // R12
endmodule

// File: rtl/dma_slave_req.sv
module dma_slave_req
  import dma_slave_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgAckOnly,
  input  logic               cfgBurst,
  input  logic [BURST_W-1:0] cfgBurstLen,
  input  logic               cfgWide,
  input  logic               cfgCntEn,
  input  logic               cfgShortEn,
  input  logic               cfgAutoReload,
  input  logic               cfgReqPol,
  input  logic               cfgAckPol,
  input  logic               cfgEotPol,
  input  logic [CNT_W-1:0]   cfgCount,
  input  logic               epIsIn,
  input  logic               fifoPktReady,
  input  logic               fifoSpace,
  input  logic               fifoShort,
  input  logic               fifoLast,
  input  logic               fifoEmptyPkt,
  input  logic [DATA_W-1:0]  fifoRdData,
  input  logic               busAck,
  input  logic               busEot,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [DATA_W-1:0]  busDataIn,
  output logic               dmaReq,
  output logic [DATA_W-1:0]  busDataOut,
  output logic               busDataOe,
  output logic               fifoRd,
  output logic               fifoWr,
  output logic [DATA_W-1:0]  fifoWrData,
  output logic               fifoFlush,
  output logic               fifoCommit,
  output logic               xferDone,
  output logic [CAUSE_W-1:0] termCause
);
  dpStrobes_t strb;
  logic       cntWillZero;

  dma_slave_ctrl #(.BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgAckOnly(cfgAckOnly),
    .cfgBurst(cfgBurst), .cfgBurstLen(cfgBurstLen), .cfgCntEn(cfgCntEn),
    .cfgShortEn(cfgShortEn), .cfgAutoReload(cfgAutoReload),
    .cfgReqPol(cfgReqPol), .cfgAckPol(cfgAckPol), .cfgEotPol(cfgEotPol),
    .epIsIn(epIsIn), .fifoPktReady(fifoPktReady), .fifoSpace(fifoSpace),
    .fifoShort(fifoShort), .fifoLast(fifoLast), .fifoEmptyPkt(fifoEmptyPkt),
    .busAck(busAck), .busEot(busEot), .busRd(busRd), .busWr(busWr),
    .cntWillZero(cntWillZero), .strb(strb), .dmaReq(dmaReq),
    .fifoFlush(fifoFlush), .fifoCommit(fifoCommit),
    .xferDone(xferDone), .termCause(termCause)
  );

  dma_slave_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWide(cfgWide),
    .cfgCount(cfgCount), .fifoRdData(fifoRdData), .busDataIn(busDataIn),
    .cntWillZero(cntWillZero), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .fifoRd(fifoRd), .fifoWr(fifoWr), .fifoWrData(fifoWrData)
  );
endmodule

// File: tb/dma_slave_req_bench.sv
module dma_slave_req_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 0, cfgAckOnly = 0, cfgBurst = 0, cfgWide = 0;
  logic [3:0] cfgBurstLen = 0;
  logic cfgCntEn = 0, cfgShortEn = 0, cfgAutoReload = 0;
  logic cfgReqPol = 1, cfgAckPol = 1, cfgEotPol = 1;
  logic [15:0] cfgCount = 0;
  logic epIsIn = 0, fifoPktReady = 1, fifoSpace = 1;
  logic fifoShort = 0, fifoLast = 0, fifoEmptyPkt = 0;
  logic [15:0] fifoRdData = 16'hA5C3;
  logic busAck = 0, busEot = 0, busRd = 0, busWr = 0;
  logic [15:0] busDataIn = 16'h3C5A;
  logic dmaReq, busDataOe, fifoRd, fifoWr, fifoFlush, fifoCommit, xferDone;
  logic [15:0] busDataOut, fifoWrData;
  logic [3:0] termCause;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_slave_req u_dma_slave_req (.*);

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int reqOn();
    return int'(dmaReq == cfgReqPol);
  endfunction

  task automatic startDma();
    @(negedge clk) cfgEnable = 0;
    @(negedge clk) cfgEnable = 1;
    @(negedge clk);
  endtask

  // one full strobe; returns whether a FIFO pulse followed
  task automatic pulse(output bit seen);
    @(negedge clk);
    busAck = cfgAckPol;
    if (!cfgAckOnly) begin
      if (epIsIn) busWr = 1; else busRd = 1;
    end
    @(negedge clk);
    seen = fifoRd | fifoWr;
    busAck = !cfgAckPol; busRd = 0; busWr = 0;
  endtask

  task automatic pulseEot();
    @(negedge clk) busEot = cfgEotPol;
    @(negedge clk);
  endtask

  initial begin
    bit seen;
    int got;
    busAck = !cfgAckPol; busEot = !cfgEotPol;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R12 reset done", xferDone, 0);
    check("R12 reset cause", termCause, 0);
    check("R1 reset req idle", reqOn(), 0);

    // polarity sweep: request level, ack level, eot level
    for (int p = 0; p < 8; p++) begin
      @(negedge clk) cfgEnable = 0;
      cfgReqPol = p[0]; cfgAckPol = p[1]; cfgEotPol = p[2];
      busAck = !cfgAckPol; busEot = !cfgEotPol;
      epIsIn = 0; cfgAckOnly = p[0];
      @(negedge clk);
      check("R1 idle req level", dmaReq, !cfgReqPol);
      startDma();
      check("R1 active req level", dmaReq, cfgReqPol);
      pulse(seen);
      check("R1 ack polarity transfer", seen, 1);
      pulseEot();
      check("R6 eot polarity cause", termCause, 4'b0001);
      check("R6 OUT eot flush", fifoFlush, 1);
      busEot = !cfgEotPol;
    end
    cfgReqPol = 1; cfgAckPol = 1; cfgEotPol = 1;
    busAck = 0; busEot = 0;

    // count sweep
    cfgCntEn = 1;
    for (int ao = 0; ao < 2; ao++)
      for (int w = 0; w < 2; w++)
        for (int n = 1; n <= 6; n++) begin
          cfgAckOnly = ao[0]; cfgWide = w[0]; cfgCount = 16'(n);
          epIsIn = n[0];
          startDma();
          got = 0;
          for (int k = 0; k < 20 && !xferDone; k++) begin
            pulse(seen);
            got += int'(seen);
          end
          check("R5 transfers for count", got, (n + w + 1 - 1) / (w + 1));
          check("R5 count cause", termCause, 4'b0010);
          @(negedge clk);
          check("R5 req off after count", reqOn(), 0);
        end
    cfgCntEn = 0; cfgWide = 0;

    // R3 ignore cases
    epIsIn = 0; cfgAckOnly = 0;
    startDma();
    check("R12 status cleared on enable", xferDone, 0);
    @(negedge clk) busAck = 1;
    @(negedge clk) check("R3 ack without rd moves nothing", fifoRd, 0);
    @(negedge clk) busAck = 0;
    @(negedge clk) busRd = 1;
    @(negedge clk) check("R3 rd without ack moves nothing", fifoRd, 0);
    busRd = 0;
    cfgAckOnly = 1;
    @(negedge clk) busRd = 1;
    @(negedge clk) check("R3 rd ignored in ack-only", fifoRd, 0);
    busRd = 0;

    // R4 single: request drops and returns
    cfgAckOnly = 0; cfgBurst = 0;
    startDma();
    @(negedge clk) begin busAck = 1; busRd = 1; end
    @(negedge clk) begin
      check("R4 single drop", reqOn(), 0);
      busAck = 0; busRd = 0;
    end
    @(negedge clk) check("R4 single return", reqOn(), 1);

    // R4 burst of 4
    cfgBurst = 1; cfgBurstLen = 3;
    startDma();
    @(negedge clk) busAck = 1;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk) busRd = 1;
      @(negedge clk) busRd = 0;
      check("R4 burst req", reqOn(), (b < 3) ? 1 : 0);
    end
    @(negedge clk) busAck = 0;
    @(negedge clk) check("R4 burst return", reqOn(), 1);
    cfgBurst = 0;

    // R11 data paths
    for (int w = 0; w < 2; w++) begin
      cfgWide = w[0]; epIsIn = 0;
      startDma();
      @(negedge clk) begin busAck = 1; busRd = 1; end
      #1;
      check("R11 OUT oe", busDataOe, 1);
      check("R11 OUT data", busDataOut, w ? 16'hA5C3 : 16'h00C3);
      @(negedge clk) begin
        check("R11 OUT pop", fifoRd, 1);
        busAck = 0; busRd = 0;
      end
      epIsIn = 1;
      startDma();
      pulse(seen);
      check("R11 IN push", seen, 1);
      check("R11 IN data", fifoWrData, w ? 16'h3C5A : 16'h005A);
    end
    cfgWide = 0;

    // R6 IN eot commit
    epIsIn = 1;
    startDma();
    pulseEot();
    check("R6 IN commit", fifoCommit, 1);
    check("R6 IN eot cause", termCause, 4'b0001);
    busEot = 0;

    // R7 short packet
    epIsIn = 0; cfgAckOnly = 1; fifoShort = 1; fifoLast = 1;
    cfgShortEn = 0;
    startDma();
    pulse(seen);
    check("R7 short ignored when off", xferDone, 0);
    cfgShortEn = 1;
    startDma();
    pulse(seen);
    check("R7 short terminates", termCause, 4'b0100);
    fifoShort = 0; fifoLast = 0;

    // R8 empty packet
    fifoEmptyPkt = 1;
    startDma();
    check("R8 empty blocks req", reqOn(), 0);
    @(negedge clk);
    check("R8 empty cause", termCause, 4'b0100);
    check("R8 empty flush", fifoFlush, 1);
    fifoEmptyPkt = 0; cfgShortEn = 0;

    // R9 disable, and priority over eot (R12)
    startDma();
    @(negedge clk) cfgEnable = 0;
    @(negedge clk) check("R9 disable cause", termCause, 4'b1000);
    startDma();
    @(negedge clk) begin cfgEnable = 0; busEot = 1; end
    @(negedge clk) check("R12 disable beats eot", termCause, 4'b1000);
    busEot = 0;

    // R10 auto reload, IN
    epIsIn = 1; cfgCntEn = 1; cfgAutoReload = 1; cfgCount = 2;
    startDma();
    pulse(seen);
    pulseEot();
    busEot = 0;
    check("R10 eot cause", termCause, 4'b0001);
    check("R10 IN req at once", reqOn(), 1);
    pulse(seen);
    check("R10 reloaded one left", termCause, 4'b0001);
    pulse(seen);
    check("R10 reloaded count end", termCause, 4'b0010);
    @(negedge clk) check("R10 still running", reqOn(), 1);

    // R10 OUT waits for packet
    epIsIn = 0;
    startDma();
    pulse(seen);
    fifoPktReady = 0;
    pulse(seen);
    @(negedge clk) check("R10 OUT wait no packet", reqOn(), 0);
    fifoPktReady = 1;
    @(negedge clk) check("R10 OUT resumes", reqOn(), 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule